// File: doc/BRIEF.md
# EDO DRAM Controller with CAS-before-RAS Refresh

This block connects a simple single-beat host bus to a 32-bit, 1-Mbyte memory built from two 256K x 16 extended-data-out DRAM devices. The host offers a word address, four byte enables, write data and a direction bit. It holds `reqValid` until the controller raises `reqReady` at a clock edge. The controller then runs one complete DRAM cycle. It multiplexes the row and column halves of the word address onto a 9-bit device address bus and drives one row strobe that both devices share. It drives one column strobe per byte lane, with lanes 0 and 1 on the device that carries data bits 15:0 and lanes 2 and 3 on the device that carries bits 31:16. It drives a write enable and a separate output enable. When the cycle ends, `ackValid` pulses for one clock, with the read word on `ackRdata` for a read.

An interval counter keeps refresh going without host involvement. At 25 MHz, 512 rows in 8 ms comes to one refresh every 390 clocks. When the counter expires it sets a pending flag. That flag is served at the next idle cycle, ahead of any waiting host request, with a CAS-before-RAS refresh. Every timing figure (row-to-column delay, column pulse width, precharge, refresh pulse width, refresh interval) is a fixed parameter counted in clock cycles.

Top module: `edoDramCtl`

## Requirements
- R1: While reset is asserted and during every idle cycle, `ramRasN`, all four `ramCasN` bits, `ramWeN` and `ramOeN` are high, `ramDoutEn` and `ackValid` are low, and `reqReady` is high unless a refresh is pending.
- R2: A request is accepted at the clock edge where `reqValid` and `reqReady` are both high. In the cycle that follows, `ramAddr` carries the row (word address bits 17:9) with `ramRasN` still high. `ramRasN` then goes low for `T_RCD` cycles while the row stays on `ramAddr`.
- R3: Once the `T_RCD` cycles have elapsed, `ramAddr` switches to the column (word address bits 8:0) and the column phase lasts `T_CAS` cycles with `ramRasN` held low.
- R4: During the column phase, `ramCasN[i]` is low exactly when `reqBe[i]` was set at acceptance. Bits 0 and 1 select `ramDin`/`ramDout` bytes 7:0 and 15:8 on the low device. Bits 2 and 3 select bytes 23:16 and 31:24 on the high device.
- R5: For a read (`reqWrite` = 0), `ramOeN` is low and `ramWeN` high throughout the column phase. `ramDin` is captured at the edge that ends the last column cycle. Bytes whose strobe stayed high read back as whatever `ramDin` held.
- R6: For a write (`reqWrite` = 1), `ramWeN` is low, `ramOeN` is high, and `ramDout` carries the accepted write data with `ramDoutEn` high throughout the column phase, and at no other time.
- R7: In the cycle right after the column phase, all strobes are high and `ackValid` is high for exactly that one cycle. `ackRdata` holds the captured word for a read.
- R8: After any DRAM cycle or refresh, `ramRasN` stays high for at least `T_RP` cycles before it falls again.
- R9: A refresh becomes pending every `REF_INTERVAL` clock edges after reset (390 by default), and an idle controller starts it in the next cycle.
- R10: A refresh drives all four `ramCasN` low for one cycle with `ramRasN` high. It then holds both low for `T_REFW` cycles and releases them together, with `ramWeN` and `ramOeN` high throughout.
- R11: A pending refresh takes priority over a host request that is waiting in the same idle cycle. The request is accepted only after the refresh and its precharge.
- R12: `reqReady` is high only in idle cycles with no refresh pending. No request is taken while a DRAM cycle or a refresh is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Controller takes the request at this edge |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 18 | Word address: row in bits 17:9, column in bits 8:0 |
| reqBe | input | 4 | Byte enables, bit i for data byte i |
| reqWdata | input | 32 | Write data |
| ackValid | output | 1 | One-cycle completion pulse |
| ackRdata | output | 32 | Read data, valid with the pulse of a read |
| ramAddr | output | 9 | Multiplexed row/column address to both devices |
| ramRasN | output | 1 | Shared row strobe, active low |
| ramCasN | output | 4 | Per-byte column strobes, active low |
| ramWeN | output | 1 | Write enable, active low |
| ramOeN | output | 1 | Output enable, active low |
| ramDout | output | 32 | Data toward the devices |
| ramDoutEn | output | 1 | Drive enable for `ramDout` |
| ramDin | input | 32 | Data from the devices |

## Verification
The bench builds the block with `T_RCD` = 3, `T_CAS` = 2, `T_RP` = 2, `T_REFW` = 2 and `REF_INTERVAL` = 47. The row-to-column delay and the column width then differ from each other, so a swapped counter load shows up on the pins. The short refresh interval lets one run see dozens of refreshes. Many of them fall on an idle controller, and others land while a request is waiting or while back-to-back requests are queued, which exercises the refresh-versus-host priority. Ready, strobes, address halves, write data and acknowledge are compared with the reference schedule on every clock.

// File: rtl/edoDramPkg.sv
package edoDramPkg;

  // Strobes from the sequencer to the datapath, one bit per pin group.
  typedef struct packed {
    logic load;      // latch the host request this edge
    logic rasOn;     // row strobe active
    logic casBeOn;   // column strobes active on enabled lanes (access)
    logic casAllOn;  // all column strobes active (refresh)
    logic colSel;    // present column half of the address
    logic capture;   // sample read data this edge
    logic ack;       // completion pulse
  } edoStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_RCD,
    ST_CAS,
    ST_ACK,
    ST_PRE,
    ST_RCBR,
    ST_RBOTH
  } edoState_t;

endpackage

// File: rtl/edoDramSeq.sv
module edoDramSeq
  import edoDramPkg::*;
#(
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_RP         = 2,
  parameter int T_REFW       = 3,
  parameter int REF_INTERVAL = 390
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  output edoStrobe_t strobe
);

  localparam int MAX_AB = (T_RCD > T_CAS) ? T_RCD : T_CAS;
  localparam int MAX_CD = (T_RP > T_REFW) ? T_RP : T_REFW;
  localparam int MAX_T  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W  = $clog2(MAX_T + 1);
  localparam int REF_W  = $clog2(REF_INTERVAL);

  edoState_t        state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic [REF_W-1:0] refCnt;
  logic             refPend;
  logic             refTick;
  logic             refTake;
  logic             cntZero;

  assign cntZero = (cnt == '0);
  assign refTick = (refCnt == '0);
  assign refTake = (state == ST_IDLE) && refPend;

  // Next-state and phase counter
  always_comb begin
    stateNxt = state;
    cntNxt   = cntZero ? cnt : cnt - 1'b1;
    unique case (state)
      ST_IDLE: begin
        if (refPend)       stateNxt = ST_RCBR;
        else if (reqValid) stateNxt = ST_SETUP;
      end
      ST_SETUP: begin
        stateNxt = ST_RCD;
        cntNxt   = CNT_W'(T_RCD - 1);
      end
      ST_RCD: begin
        if (cntZero) begin
          stateNxt = ST_CAS;
          cntNxt   = CNT_W'(T_CAS - 1);
        end
      end
      ST_CAS: begin
        if (cntZero) stateNxt = ST_ACK;
      end
      ST_ACK: begin
        stateNxt = ST_PRE;
        cntNxt   = CNT_W'(T_RP - 1);
      end
      ST_PRE: begin
        if (cntZero) stateNxt = ST_IDLE;
      end
      ST_RCBR: begin
        stateNxt = ST_RBOTH;
        cntNxt   = CNT_W'(T_REFW - 1);
      end
      ST_RBOTH: begin
        if (cntZero) begin
          stateNxt = ST_PRE;
          cntNxt   = CNT_W'(T_RP - 1);
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
    end
  end

  // Refresh pacing: a new expiry outranks the clear of the previous one
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refCnt  <= REF_W'(REF_INTERVAL - 1);
      refPend <= 1'b0;
    end else begin
      refCnt <= refTick ? REF_W'(REF_INTERVAL - 1) : refCnt - 1'b1;
      if (refTick)      refPend <= 1'b1;
      else if (refTake) refPend <= 1'b0;
    end
  end

  // Strobe decode from the registered state
  always_comb begin
    strobe   = '0;
    reqReady = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady    = !refPend;
        strobe.load = reqValid && !refPend;
      end
      ST_RCD: strobe.rasOn = 1'b1;
      ST_CAS: begin
        strobe.rasOn   = 1'b1;
        strobe.casBeOn = 1'b1;
        strobe.colSel  = 1'b1;
        strobe.capture = cntZero;
      end
      ST_ACK:  strobe.ack = 1'b1;
      ST_RCBR: strobe.casAllOn = 1'b1;
      ST_RBOTH: begin
        strobe.casAllOn = 1'b1;
        strobe.rasOn    = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/edoDramPath.sv
module edoDramPath
  import edoDramPkg::*;
#(
  parameter int ROW_W  = 9,
  parameter int COL_W  = 9,
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  edoStrobe_t                strobe,
  input  logic                      reqWrite,
  input  logic [ROW_W+COL_W-1:0]    reqAddr,
  input  logic [DATA_W/8-1:0]       reqBe,
  input  logic [DATA_W-1:0]         reqWdata,
  output logic                      ackValid,
  output logic [DATA_W-1:0]         ackRdata,
  output logic [ROW_W-1:0]          ramAddr,
  output logic                      ramRasN,
  output logic [DATA_W/8-1:0]       ramCasN,
  output logic                      ramWeN,
  output logic                      ramOeN,
  output logic [DATA_W-1:0]         ramDout,
  output logic                      ramDoutEn,
  input  logic [DATA_W-1:0]         ramDin
);

  localparam int ADDR_W = ROW_W + COL_W;
  localparam int BE_W   = DATA_W / 8;

  logic [ROW_W-1:0]  rowReg;
  logic [COL_W-1:0]  colReg;
  logic [BE_W-1:0]   beReg;
  logic              wrReg;
  logic [DATA_W-1:0] wdReg;
  logic [DATA_W-1:0] rdReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowReg <= '0;
      colReg <= '0;
      beReg  <= '0;
      wrReg  <= 1'b0;
      wdReg  <= '0;
    end else if (strobe.load) begin
      rowReg <= reqAddr[ADDR_W-1 -: ROW_W];
      colReg <= reqAddr[COL_W-1:0];
      beReg  <= reqBe;
      wrReg  <= reqWrite;
      wdReg  <= reqWdata;
    end
  end

  // Per-lane column strobe and read capture
  for (genvar lane = 0; lane < BE_W; lane++) begin : g_lane
    assign ramCasN[lane] = strobe.casAllOn ? 1'b0
                                           : !(strobe.casBeOn && beReg[lane]);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        rdReg[8*lane +: 8] <= '0;
      else if (strobe.capture && !wrReg)
        rdReg[8*lane +: 8] <= ramDin[8*lane +: 8];
    end
  end

  assign ramAddr   = strobe.colSel ? ROW_W'(colReg) : rowReg;
  assign ramRasN   = !strobe.rasOn;
  assign ramWeN    = !(strobe.casBeOn && wrReg);
  assign ramOeN    = !(strobe.casBeOn && !wrReg);
  assign ramDoutEn = strobe.casBeOn && wrReg;
  assign ramDout   = wdReg;
  assign ackValid  = strobe.ack;
  assign ackRdata  = rdReg;

endmodule

// File: rtl/edoDramCtl.sv
module edoDramCtl
  import edoDramPkg::*;
#(
  parameter int ROW_W        = 9,
  parameter int COL_W        = 9,
  parameter int DATA_W       = 32,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_RP         = 2,
  parameter int T_REFW       = 3,
  parameter int REF_INTERVAL = 390
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic                    reqWrite,
  input  logic [ROW_W+COL_W-1:0]  reqAddr,
  input  logic [DATA_W/8-1:0]     reqBe,
  input  logic [DATA_W-1:0]       reqWdata,
  output logic                    ackValid,
  output logic [DATA_W-1:0]       ackRdata,
  output logic [ROW_W-1:0]        ramAddr,
  output logic                    ramRasN,
  output logic [DATA_W/8-1:0]     ramCasN,
  output logic                    ramWeN,
  output logic                    ramOeN,
  output logic [DATA_W-1:0]       ramDout,
  output logic                    ramDoutEn,
  input  logic [DATA_W-1:0]       ramDin
);

  localparam int BE_W = DATA_W / 8;

  edoStrobe_t strobe;

  edoDramSeq #(
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP),
    .T_REFW(T_REFW), .REF_INTERVAL(REF_INTERVAL)
  ) i_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .reqReady(reqReady), .strobe(strobe)
  );

  edoDramPath #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)
  ) i_path (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqBe(reqBe), .reqWdata(reqWdata),
    .ackValid(ackValid), .ackRdata(ackRdata),
    .ramAddr(ramAddr), .ramRasN(ramRasN), .ramCasN(ramCasN),
    .ramWeN(ramWeN), .ramOeN(ramOeN),
    .ramDout(ramDout), .ramDoutEn(ramDoutEn), .ramDin(ramDin)
  );

endmodule

// File: rtl/edoDramChk.sv
module edoDramChk #(
  parameter int T_RP = 2,
  parameter int BE_W = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqReady,
  input logic            ackValid,
  input logic            ramRasN,
  input logic [BE_W-1:0] ramCasN,
  input logic            ramWeN,
  input logic            ramOeN,
  input logic            ramDoutEn
);

  localparam int CW = $clog2(T_RP + 1) + 1;

  // Consecutive cycles of row strobe high, saturating at T_RP
  logic [CW-1:0] hiCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  hiCnt <= CW'(T_RP);
    else if (!ramRasN)          hiCnt <= '0;
    else if (hiCnt < CW'(T_RP)) hiCnt <= hiCnt + 1'b1;
  end

  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (ramRasN && (ramCasN == '1))); // R12

  AST_NO_WE_OE_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    !(!ramWeN && !ramOeN)); // R5

  AST_WE_HAS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (!ramWeN) |-> ramDoutEn); // R6

  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |=> !ackValid); // R7

  AST_PRECHARGE_MIN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ramRasN) |-> (hiCnt >= CW'(T_RP))); // R8

  AST_CBR_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ramRasN) |-> ((ramCasN == '1) || ($past(ramCasN) == '0))); // R10

  AST_LANE_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rstN)
    ((ramCasN != '1) && (ramCasN != '0)) |-> !ramRasN); // R4

endmodule

bind edoDramCtl edoDramChk #(.T_RP(T_RP), .BE_W(BE_W)) i_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .ackValid(ackValid),
  .ramRasN(ramRasN), .ramCasN(ramCasN), .ramWeN(ramWeN), .ramOeN(ramOeN),
  .ramDoutEn(ramDoutEn)
);

// File: tb/test_edoDramCtl.sv
`timescale 1ns/1ps
module test_edoDramCtl;

  localparam int T_RCD = 3, T_CAS = 2, T_RP = 2, T_REFW = 2, REF_INTERVAL = 47;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [17:0] reqAddr = '0;
  logic [3:0]  reqBe = '0;
  logic [31:0] reqWdata = '0;
  logic        ackValid;
  logic [31:0] ackRdata;
  logic [8:0]  ramAddr;
  logic        ramRasN;
  logic [3:0]  ramCasN;
  logic        ramWeN, ramOeN, ramDoutEn;
  logic [31:0] ramDout;
  logic [31:0] ramDin;

  always #2.5 clk = ~clk;

  edoDramCtl #(
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP),
    .T_REFW(T_REFW), .REF_INTERVAL(REF_INTERVAL)
  ) i_edoDramCtl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqBe(reqBe), .reqWdata(reqWdata),
    .ackValid(ackValid), .ackRdata(ackRdata), .ramAddr(ramAddr),
    .ramRasN(ramRasN), .ramCasN(ramCasN), .ramWeN(ramWeN), .ramOeN(ramOeN),
    .ramDout(ramDout), .ramDoutEn(ramDoutEn), .ramDin(ramDin)
  );

  typedef struct packed {
    logic        ras;
    logic [3:0]  cas;
    logic        we;
    logic        oe;
    logic        doutEn;
    logic [31:0] dout;
    logic        addrChk;
    logic [8:0]  addr;
    logic        ack;
    logic        rdChk;
    logic [31:0] rdata;
    logic [3:0]  tag;
    logic [3:0]  aTag;
    logic [3:0]  cTag;
  } expCycle_t;

  expCycle_t   schedQ[$];
  logic [31:0] memModel [int];
  logic [31:0] rdWord = '0;
  bit          refOwed = 0;
  int          edgeCount = 0;
  int          total = 0;
  int          bad = 0;

  function automatic string tagName(input logic [3:0] t);
    case (t)
      4'd1:  return "R1";
      4'd2:  return "R2";
      4'd3:  return "R3";
      4'd4:  return "R4";
      4'd5:  return "R5";
      4'd6:  return "R6";
      4'd7:  return "R7";
      4'd8:  return "R8";
      4'd9:  return "R9";
      4'd10: return "R10";
      4'd11: return "R11";
      4'd12: return "R12";
      default: return "R?";
    endcase
  endfunction

  function automatic logic [31:0] memRead(input int a);
    if (memModel.exists(a)) return memModel[a];
    return (32'(a) * 32'h9E3779B1) ^ 32'h5A5AC3C3;
  endfunction

  function automatic expCycle_t mkIdle(input logic [3:0] t);
    expCycle_t e;
    e = '0;
    e.ras = 1'b1; e.cas = 4'hF; e.we = 1'b1; e.oe = 1'b1;
    e.tag = t; e.aTag = t; e.cTag = t;
    return e;
  endfunction

  task automatic chk(input bit ok, input logic [3:0] t, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h at %0t", tagName(t), what, act, exp, $time);
    end
  endtask

  // Memory behaviour: enabled lanes return data while output enable is low
  always_comb begin
    for (int b = 0; b < 4; b++)
      ramDin[8*b +: 8] = (!ramOeN && !ramCasN[b]) ? rdWord[8*b +: 8] : 8'h00;
  end

  // Reference schedule, advanced on every rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      schedQ.delete();
      refOwed = 0;
      edgeCount = 0;
    end else begin
      bit wasIdle;
      expCycle_t e;
      edgeCount++;
      wasIdle = (schedQ.size() == 0);
      if (!wasIdle) begin
        void'(schedQ.pop_front());
      end else if (refOwed) begin
        refOwed = 0;
        // R9 when nothing waits, R11 when a request is held off
        e = mkIdle(reqValid ? 4'd11 : 4'd9);
        e.cas = 4'h0;
        schedQ.push_back(e);
        e = mkIdle(4'd10);
        e.ras = 1'b0; e.cas = 4'h0;
        for (int k = 0; k < T_REFW; k++) schedQ.push_back(e);
        for (int k = 0; k < T_RP; k++) schedQ.push_back(mkIdle(4'd8));
      end else if (reqValid) begin
        logic [31:0] oldW, newW, rdExp;
        int a;
        a = int'(reqAddr);
        oldW = memRead(a);
        newW = oldW;
        rdExp = '0;
        for (int b = 0; b < 4; b++) begin
          if (reqBe[b]) begin
            newW[8*b +: 8] = reqWdata[8*b +: 8];
            rdExp[8*b +: 8] = oldW[8*b +: 8];
          end
        end
        if (reqWrite) memModel[a] = newW;
        else rdWord = oldW;
        e = mkIdle(4'd2);
        e.addrChk = 1'b1; e.addr = reqAddr[17:9];
        schedQ.push_back(e);
        e.ras = 1'b0;
        for (int k = 0; k < T_RCD; k++) schedQ.push_back(e);
        e = mkIdle(reqWrite ? 4'd6 : 4'd5);
        e.ras = 1'b0; e.cas = ~reqBe; e.cTag = 4'd4;
        e.addrChk = 1'b1; e.addr = reqAddr[8:0]; e.aTag = 4'd3;
        e.we = !reqWrite; e.oe = reqWrite;
        e.doutEn = reqWrite; e.dout = reqWdata;
        for (int k = 0; k < T_CAS; k++) schedQ.push_back(e);
        e = mkIdle(4'd7);
        e.ack = 1'b1; e.rdChk = !reqWrite; e.rdata = rdExp;
        schedQ.push_back(e);
        for (int k = 0; k < T_RP; k++) schedQ.push_back(mkIdle(4'd8));
      end
      if ((edgeCount % REF_INTERVAL) == 0) refOwed = 1;
    end
  end

  // Comparison away from the active edge
  always @(negedge clk) begin
    expCycle_t e;
    e = (schedQ.size() != 0) ? schedQ[0] : mkIdle(4'd1);
    chk(ramRasN === e.ras, e.tag, "ramRasN", 32'(ramRasN), 32'(e.ras));
    chk(ramCasN === e.cas, e.cTag, "ramCasN", 32'(ramCasN), 32'(e.cas));
    chk(ramWeN === e.we, e.tag, "ramWeN", 32'(ramWeN), 32'(e.we));
    chk(ramOeN === e.oe, e.tag, "ramOeN", 32'(ramOeN), 32'(e.oe));
    chk(ramDoutEn === e.doutEn, e.tag, "ramDoutEn", 32'(ramDoutEn), 32'(e.doutEn));
    if (e.doutEn) chk(ramDout === e.dout, e.tag, "ramDout", ramDout, e.dout);
    if (e.addrChk) chk(ramAddr === e.addr, e.aTag, "ramAddr", 32'(ramAddr), 32'(e.addr));
    chk(ackValid === e.ack, 4'd7, "ackValid", 32'(ackValid), 32'(e.ack));
    if (e.rdChk) chk(ackRdata === e.rdata, 4'd5, "ackRdata", ackRdata, e.rdata);
    chk(reqReady === ((schedQ.size() == 0) && !refOwed), 4'd12, "reqReady",
        32'(reqReady), 32'((schedQ.size() == 0) && !refOwed));
  end

  // Called and returns at a falling edge
  task automatic doReq(input bit wr, input logic [17:0] a, input logic [3:0] be,
                       input logic [31:0] d, input bit waitAck);
    bit rdy;
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqBe = be; reqWdata = d;
    forever begin
      rdy = reqReady;
      @(posedge clk);
      if (rdy) break;
      @(negedge clk);
    end
    @(negedge clk);
    reqValid = 1'b0;
    reqWdata = $urandom;
    if (waitAck) while (!ackValid) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R12 watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [17:0] pick [4];
    pick[0] = 18'h00000; pick[1] = 18'h3FFFF; pick[2] = 18'h155AA; pick[3] = 18'h00123;
    repeat (4) @(negedge clk);   // R1: reset state compared each cycle
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // R2 R3 R6: full-word writes at address extremes
    doReq(1'b1, 18'h00000, 4'hF, 32'h11223344, 1'b1);
    doReq(1'b1, 18'h3FFFF, 4'hF, 32'hA5A5F00F, 1'b1);
    doReq(1'b1, 18'h155AA, 4'hF, 32'hCAFEBABE, 1'b1);
    // R4: single-device and alternating lane writes
    doReq(1'b1, 18'h00123, 4'h3, 32'h0000BEEF, 1'b1);
    doReq(1'b1, 18'h00123, 4'hC, 32'hDEAD0000, 1'b1);
    doReq(1'b1, 18'h00123, 4'h5, 32'h00770077, 1'b1);
    // R5 R7: reads with several lane masks, including none
    doReq(1'b0, 18'h3FFFF, 4'hF, 32'h0, 1'b1);
    doReq(1'b0, 18'h00123, 4'hF, 32'h0, 1'b1);
    doReq(1'b0, 18'h00123, 4'h3, 32'h0, 1'b1);
    doReq(1'b0, 18'h00123, 4'hC, 32'h0, 1'b1);
    doReq(1'b0, 18'h00000, 4'h0, 32'h0, 1'b1);
    // R9 R10: idle long enough for refreshes on their own
    repeat (150) @(negedge clk);
    // R8 R11 R12: back-to-back and spaced traffic crossing refresh points
    for (int n = 0; n < 80; n++) begin
      logic [17:0] a;
      a = (($urandom % 3) == 0) ? 18'($urandom) : pick[$urandom % 4];
      doReq(1'($urandom), a, 4'($urandom), $urandom, 1'($urandom));
      repeat ($urandom % 4) @(negedge clk);
    end
    repeat (40) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule